// File: doc/BRIEF.md
# Coarse/Fine Event Timestamp Capture

This block builds event timestamps for a time-to-digital converter. A coarse counter runs freely in the system clock domain and counts whole clock periods. A row of fine sample bits comes from flip-flops that all sample one hit signal, each through a different tap of a delay chain. The block watches the lowest-delay tap for the selected edge. When that edge arrives it captures the coarse count and the fine pattern together, in the same clock. It turns the pattern into a tap index and reports one combined time value along with a valid strobe.

The combined time is given in a single unit, the tap delay unit. The clock period is a whole number of taps (`TAPS_PER_CLK`). The output therefore equals the coarse count times the clock period plus the fine index times the tap delay. A select input picks rising or falling events. For falling events the fine pattern is inverted before the search, so that a falling wave front gives a thermometer of ones in the same way a rising one does. Building the physical delay chain and calibrating it is left to the surrounding design.

Top module: `tdc_stamp`

## Requirements
- R1: While `rst` is high at a clock edge, `ts_valid`, `ts_ovf`, `ts_coarse`, `ts_fine` and `ts_time` are cleared to zero after that edge.
- R2: The coarse counter is 0 after reset. It rises by one at every clock edge with `rst` low and wraps from 2^CNT_W-1 to 0.
- R3: With `edge_sel`=0 (rising mode), an event is detected at a clock edge where `fine_bits[0]` is 1 and was 0 at the previous edge. `ts_valid` is then high for exactly the one cycle after that edge.
- R4: With `edge_sel`=1 (falling mode), an event is detected at an edge where `fine_bits[0]` is 0 and was 1 at the previous edge. The fine vector is bitwise inverted before it is encoded.
- R5: `ts_fine` is the index of the highest set bit of the polarity-adjusted fine vector, where bit 0 is the lowest-delay tap. Patterns with bubbles (gaps) are included. It is 0 if no bit is set.
- R6: If every bit of the adjusted vector is set, `ts_fine` is NTAPS-1 and `ts_ovf` is 1. For any other pattern, `ts_ovf` is 0.
- R7: `ts_time` = (`ts_coarse` × TAPS_PER_CLK + `ts_fine`) × TAP_DELAY.
- R8: No capture happens while `fine_bits[0]` is steady or moves in the unselected direction. While `ts_valid` is low, `ts_coarse`, `ts_fine` and `ts_ovf` keep the last captured values.
- R9: `ts_coarse` holds the counter value at the clock edge where the event was detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| edge_sel | input | 1 | 0 = capture rising events, 1 = capture falling events |
| fine_bits | input | NTAPS | Delay-chain samples, bit 0 = lowest delay |
| ts_valid | output | 1 | One-cycle strobe for a new timestamp |
| ts_coarse | output | CNT_W | Captured coarse count |
| ts_fine | output | $clog2(NTAPS) | Captured fine tap index |
| ts_ovf | output | 1 | Fine vector was fully set at capture |
| ts_time | output | CNT_W+$clog2(TAPS_PER_CLK*TAP_DELAY)+1 | Combined time in tap-delay units |

## Verification
The bench builds the block with 8 taps, a 6-bit coarse counter, a tap delay of 5 units and 8 taps per clock, which gives a 40-unit period. The short counter lets a run of about a hundred cycles cross the wrap from 63 to 0, so captures are seen on both sides of it. With 8 taps, every thermometer depth, the full-vector overflow case and patterns with bubbles can all be driven in both edge modes. The small numbers also keep each expected combined time easy to recompute by hand.

// File: rtl/tdc_stamp_pkg.sv
package tdc_stamp_pkg;

  // Combined time in tap-delay units: whole periods expressed as taps, plus fine taps.
  function automatic longint unsigned stamp_time(input longint unsigned coarse,
                                                 input longint unsigned fine,
                                                 input longint unsigned taps_per_clk,
                                                 input longint unsigned tap_delay);
    return (coarse * taps_per_clk + fine) * tap_delay;
  endfunction

endpackage

// File: rtl/tdc_coarse_ctr.sv
module tdc_coarse_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count
);
  // Free-running, wraps naturally at 2^CNT_W
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + 1'b1;
  end
endmodule

// File: rtl/tdc_edge_det.sv
module tdc_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic tap0,
  input  logic fall_sel,
  output logic evt
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= tap0;
  end

  // Compare the first tap against its previous-cycle sample: one event per transition
  assign evt = !rst && (fall_sel ? (prev_q && !tap0) : (!prev_q && tap0));
endmodule

// File: rtl/tdc_fine_enc.sv
module tdc_fine_enc #(
  parameter int NTAPS = 32
) (
  input  logic [NTAPS-1:0]         raw,
  input  logic                     invert,
  output logic [$clog2(NTAPS)-1:0] idx,
  output logic                     all_set
);
  localparam int FINE_W = $clog2(NTAPS);

  logic [NTAPS-1:0] adj;

  // Per-tap polarity stage
  for (genvar t = 0; t < NTAPS; t++) begin : g_pol
    assign adj[t] = raw[t] ^ invert;
  end

  // Highest set bit wins; an empty vector gives zero
  always_comb begin
    idx = '0;
    for (int i = 0; i < NTAPS; i++) begin
      if (adj[i]) idx = FINE_W'(i);
    end
  end

  assign all_set = &adj;
endmodule

// File: rtl/tdc_stamp.sv
module tdc_stamp #(
  parameter int NTAPS        = 32,
  parameter int CNT_W        = 16,
  parameter int TAP_DELAY    = 20,
  parameter int TAPS_PER_CLK = 250
) (
  input  logic                                              clk,
  input  logic                                              rst,
  input  logic                                              edge_sel,
  input  logic [NTAPS-1:0]                                  fine_bits,
  output logic                                              ts_valid,
  output logic [CNT_W-1:0]                                  ts_coarse,
  output logic [$clog2(NTAPS)-1:0]                          ts_fine,
  output logic                                              ts_ovf,
  output logic [CNT_W+$clog2(TAPS_PER_CLK*TAP_DELAY):0]     ts_time
);
  import tdc_stamp_pkg::*;

  localparam int FINE_W = $clog2(NTAPS);
  localparam int TIME_W = CNT_W + $clog2(TAPS_PER_CLK * TAP_DELAY) + 1;

  // Named internal events, visible to the bound checker
  logic              hit_evt;
  logic [CNT_W-1:0]  cnt_q;
  logic [FINE_W-1:0] fine_idx_w;
  logic              all_set_w;

  tdc_coarse_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .count (cnt_q)
  );

  tdc_edge_det u_edge (
    .clk      (clk),
    .rst      (rst),
    .tap0     (fine_bits[0]),
    .fall_sel (edge_sel),
    .evt      (hit_evt)
  );

  tdc_fine_enc #(.NTAPS(NTAPS)) u_enc (
    .raw     (fine_bits),
    .invert  (edge_sel),
    .idx     (fine_idx_w),
    .all_set (all_set_w)
  );

  // Capture coarse and fine in the same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      ts_valid  <= 1'b0;
      ts_coarse <= '0;
      ts_fine   <= '0;
      ts_ovf    <= 1'b0;
    end else begin
      ts_valid <= hit_evt;
      if (hit_evt) begin
        ts_coarse <= cnt_q;
        ts_fine   <= fine_idx_w;
        ts_ovf    <= all_set_w;
      end
    end
  end

  assign ts_time = TIME_W'(stamp_time(64'(ts_coarse), 64'(ts_fine),
                                      64'(TAPS_PER_CLK), 64'(TAP_DELAY)));
endmodule

// File: rtl/tdc_stamp_chk.sv
module tdc_stamp_chk #(
  parameter int NTAPS = 32,
  parameter int CNT_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     hit_evt,
  input logic                     all_set_w,
  input logic [CNT_W-1:0]         cnt_q,
  input logic                     ts_valid,
  input logic [CNT_W-1:0]         ts_coarse,
  input logic [$clog2(NTAPS)-1:0] ts_fine,
  input logic                     ts_ovf
);
  localparam int FINE_W = $clog2(NTAPS);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  // R3
  evt_valid_chk: assert property (@(posedge clk) disable iff (rst)
    hit_evt |=> ts_valid);

  // R8
  quiet_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !hit_evt |=> !ts_valid);

  // R8
  hold_fields_chk: assert property (@(posedge clk) disable iff (rst)
    !hit_evt |=> $stable(ts_coarse) && $stable(ts_fine) && $stable(ts_ovf));

  // R9
  coarse_capture_chk: assert property (@(posedge clk) disable iff (rst)
    hit_evt |=> ts_coarse == $past(cnt_q));

  // R6
  ovf_sat_chk: assert property (@(posedge clk) disable iff (rst)
    ts_ovf |-> ts_fine == FINE_W'(NTAPS - 1));

  // R6
  ovf_raise_chk: assert property (@(posedge clk) disable iff (rst)
    hit_evt && all_set_w |=> ts_ovf);
endmodule

bind tdc_stamp tdc_stamp_chk #(.NTAPS(NTAPS), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hit_evt   (hit_evt),
  .all_set_w (all_set_w),
  .cnt_q     (cnt_q),
  .ts_valid  (ts_valid),
  .ts_coarse (ts_coarse),
  .ts_fine   (ts_fine),
  .ts_ovf    (ts_ovf)
);

// File: tb/tdc_stamp_test.sv
`timescale 1ns/1ps
module tdc_stamp_test;
  localparam int NT  = 8;
  localparam int CW  = 6;
  localparam int TD  = 5;
  localparam int TPC = 8;
  localparam int FW  = $clog2(NT);
  localparam int TW  = CW + $clog2(TPC * TD) + 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          edge_sel;
  logic [NT-1:0] fine_bits;
  logic          ts_valid;
  logic [CW-1:0] ts_coarse;
  logic [FW-1:0] ts_fine;
  logic          ts_ovf;
  logic [TW-1:0] ts_time;

  tdc_stamp #(.NTAPS(NT), .CNT_W(CW), .TAP_DELAY(TD), .TAPS_PER_CLK(TPC)) uut (
    .clk(clk), .rst(rst), .edge_sel(edge_sel), .fine_bits(fine_bits),
    .ts_valid(ts_valid), .ts_coarse(ts_coarse), .ts_fine(ts_fine),
    .ts_ovf(ts_ovf), .ts_time(ts_time)
  );

  always #2.5 clk = ~clk;

  typedef struct { int coarse; int fine; int ovf; } item_t;
  item_t q[$];
  item_t got;
  item_t last_cap;

  int   checks = 0;
  int   errors = 0;
  int   mcnt   = 0;
  logic last_tap0;
  bit   started = 0;
  bit   done    = 0;

  function automatic void check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endfunction

  // Reference coarse count (R2): clears on reset, wraps at 2^CW
  always @(posedge clk) mcnt <= rst ? 0 : (mcnt + 1) % (1 << CW);

  function automatic logic [NT-1:0] therm(input int k);
    logic [NT-1:0] v = '0;
    for (int i = 0; i <= k; i++) v[i] = 1'b1;
    return v;
  endfunction

  // Driver: one input pattern per cycle; predicts captures
  task automatic drive(input logic [NT-1:0] bits, input logic sel);
    logic [NT-1:0] adj;
    bit            evt;
    item_t         e;
    @(negedge clk);
    fine_bits = bits;
    edge_sel  = sel;
    evt = sel ? (last_tap0 && !bits[0]) : (!last_tap0 && bits[0]);
    if (evt) begin
      adj   = sel ? ~bits : bits;
      e.fine = 0;
      for (int i = NT - 1; i >= 0; i--) begin
        if (adj[i]) begin
          e.fine = i;
          break;
        end
      end
      e.ovf    = (adj == '1) ? 1 : 0;
      e.coarse = mcnt;
      q.push_back(e);
    end
    last_tap0 = bits[0];
  endtask

  // Monitor
  always @(negedge clk) begin
    if (started && !rst) begin
      if (ts_valid) begin
        if (q.size() == 0) begin
          check("R8 unexpected valid", 1, 0);
        end else begin
          got = q.pop_front();
          check("R9 coarse", int'(ts_coarse), got.coarse);
          check("R5 fine index", int'(ts_fine), got.fine);
          check("R6 overflow", int'(ts_ovf), got.ovf);
          check("R7 time", int'(ts_time), (got.coarse * TPC + got.fine) * TD);
          last_cap = got;
        end
      end else begin
        check("R8 hold coarse", int'(ts_coarse), last_cap.coarse);
        check("R8 hold fine", int'(ts_fine), last_cap.fine);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; edge_sel = 1'b0; fine_bits = '0; last_tap0 = 1'b0;
    last_cap = '{coarse: 0, fine: 0, ovf: 0};
    repeat (3) @(negedge clk);
    // R1
    check("R1 valid", int'(ts_valid), 0);
    check("R1 coarse", int'(ts_coarse), 0);
    check("R1 fine", int'(ts_fine), 0);
    check("R1 ovf", int'(ts_ovf), 0);
    check("R1 time", int'(ts_time), 0);
    rst = 1'b0;
    started = 1;

    // R3 R5: every thermometer depth, rising mode
    for (int k = 0; k < NT - 1; k++) begin
      drive(therm(k), 1'b0);
      drive('0, 1'b0);
      drive('0, 1'b0);
    end
    // R5 bubble pattern: highest set bit is 5
    drive(8'b0010_0101, 1'b0);
    drive('0, 1'b0);
    // R6 all taps set
    drive('1, 1'b0);
    drive('0, 1'b0);
    // R8 steady high, then falling edge in rising mode: no capture
    drive(therm(3), 1'b0);
    drive(therm(5), 1'b0);
    drive('0, 1'b0);
    drive('0, 1'b0);

    // R4 falling mode
    drive('0, 1'b1);
    drive('1, 1'b1);            // rising in falling mode: R8 no capture
    drive(~therm(2), 1'b1);     // falling: adjusted fine 2
    drive('1, 1'b1);
    drive('0, 1'b1);            // adjusted all ones: R6 overflow
    drive('1, 1'b1);
    drive(~8'b0000_1001, 1'b1); // adjusted bubble, fine 3
    drive('1, 1'b1);
    drive('1, 1'b1);

    // R2 wrap of the coarse counter, then captures on the far side
    drive('0, 1'b0);
    repeat (70) drive('0, 1'b0);
    for (int k = 1; k < NT; k += 3) begin
      drive(therm(k), 1'b0);
      drive('0, 1'b0);
    end
    repeat (3) drive('0, 1'b0);

    // R3 every predicted capture appeared
    check("R3 pending captures", q.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule